// File: doc/BRIEF.md
# Test Point Control Network

This block wraps a small combinational circuit under test with addressable test points. Its internal lines can then be forced to a known level or watched from the pins. A bank of per-point configuration registers sits beside the circuit. In test mode, a write strobe stores an enable bit and a value bit into the one point selected by the shared primary inputs. Each point is built in one of three variants that repeat by index: a pull-low gate, a pull-high gate, or a two-way selector that swaps the line for the stored value.

A select input routes chosen internal lines onto the shared primary outputs, in place of the functional results. With test mode low, the register contents and the select input have no effect, so the pins behave exactly as the bare circuit. The output pins are registered. There is no data stream at the edge: every pin is a plain level sampled on the clock. There is no back-pressure and no handshake.

The circuit under test has ADDR_W inputs and 2^ADDR_W internal lines. Line i is high when the inputs equal i. Output bit j is the XOR of every line whose index modulo ADDR_W equals j.

Top module: `tp_ctrl_net`

## Requirements
- R1: While rst_n is low, po is all zeros. After reset, every point holds enable=0, value=0, so test mode alone changes nothing at the pins.
- R2: po is updated on each rising clock edge from the inputs sampled at that edge. With test_mode low, po[j] is the XOR of lines L[k] over all k with k mod ADDR_W = j, where L[k] = (pi == k). This holds whatever the stored point settings, obs_sel or cp_wr are.
- R3: A point's setting changes only at an edge where test_mode and cp_wr are both high. Only the point whose index equals pi is written, taking enable=tp_en and value=tp_val. All other points keep their settings.
- R4: A point whose index mod 3 is 0 is a pull-low point. When it is enabled and test_mode is high, its line reads 0.
- R5: A point whose index mod 3 is 1 is a pull-high point. When it is enabled and test_mode is high, its line reads 1.
- R6: A point whose index mod 3 is 2 is a replace point. When it is enabled and test_mode is high, its line carries the stored value bit.
- R7: With test_mode and obs_sel both high, po[j] shows line j after its control point, for j from 0 to ADDR_W-1. With obs_sel low, po shows the XOR results of R2, computed on the controlled lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 1 | Enables control points, writes and observation |
| cp_wr | input | 1 | Write strobe for the addressed point's setting |
| pi | input | ADDR_W | Shared primary inputs: circuit inputs and point address |
| tp_en | input | 1 | Enable bit written into the addressed point |
| tp_val | input | 1 | Value bit written into the addressed point (replace points) |
| obs_sel | input | 1 | Routes observed lines to po in test mode |
| po | output | ADDR_W | Registered shared primary outputs |

## Verification
Every input code is applied with test mode off, both with obs_sel low and high and with all points enabled. This separates true transparency from a network that merely happens to be idle.

Each point is then enabled alone and every input code is swept, through both the XOR outputs and the observation path. A point that disturbs a neighbour's line, or that uses the wrong variant, gives a different pattern. The replace point is tried with both stored values.

Writes made with test mode off, or with the strobe low, are followed by a test-mode sweep. A stored setting would show up in that sweep as a forced line.

// File: rtl/tpn_pkg.sv
package tpn_pkg;

  typedef enum logic [1:0] {
    CP_PULL_LOW  = 2'd0,
    CP_PULL_HIGH = 2'd1,
    CP_REPLACE   = 2'd2
  } cp_kind_e;

  typedef struct packed {
    logic en;
    logic val;
  } cp_cfg_t;

  // Variant of a point is chosen by its index, repeating every three points
  function automatic cp_kind_e kind_of(input int idx);
    case (idx % 3)
      0:       return CP_PULL_LOW;
      1:       return CP_PULL_HIGH;
      default: return CP_REPLACE;
    endcase
  endfunction

endpackage

// File: rtl/tpn_cfg_bank.sv
module tpn_cfg_bank
  import tpn_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int NUM_CP = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     test_mode,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     en_in,
  input  logic                     val_in,
  output cp_cfg_t [NUM_CP-1:0]     cfg_q
);

  logic [NUM_CP-1:0] hit;
  cp_cfg_t           wr_data;

  assign wr_data = '{en: en_in, val: val_in};

  // Address decoder: one strobe per point, only in test mode
  for (genvar i = 0; i < NUM_CP; i++) begin : g_dec
    assign hit[i] = test_mode & wr & (addr == ADDR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CP; i++) begin
        if (hit[i]) cfg_q[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/tpn_ctrl_point.sv
module tpn_ctrl_point
  import tpn_pkg::*;
#(
  parameter cp_kind_e KIND = CP_PULL_LOW
) (
  input  logic    line_in,
  input  logic    test_mode,
  input  cp_cfg_t cfg,
  output logic    line_out
);

  logic active;
  assign active = test_mode & cfg.en;

  if (KIND == CP_PULL_LOW) begin : g_low
    logic ctrl_n;
    assign ctrl_n   = ~active;
    assign line_out = line_in & ctrl_n;
  end else if (KIND == CP_PULL_HIGH) begin : g_high
    assign line_out = line_in | active;
  end else begin : g_repl
    assign line_out = active ? cfg.val : line_in;
  end

endmodule

// File: rtl/tpn_cut_front.sv
module tpn_cut_front #(
  parameter int ADDR_W = 2,
  localparam int NUM_CP = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] x,
  output logic [NUM_CP-1:0] lines
);

  for (genvar i = 0; i < NUM_CP; i++) begin : g_line
    assign lines[i] = (x == ADDR_W'(i));
  end

endmodule

// File: rtl/tpn_cut_back.sv
module tpn_cut_back #(
  parameter int ADDR_W = 2,
  localparam int NUM_CP = 1 << ADDR_W
) (
  input  logic [NUM_CP-1:0] lines,
  output logic [ADDR_W-1:0] y
);

  for (genvar j = 0; j < ADDR_W; j++) begin : g_out
    always_comb begin
      y[j] = 1'b0;
      for (int k = 0; k < NUM_CP; k++) begin
        if ((k % ADDR_W) == j) y[j] = y[j] ^ lines[k];
      end
    end
  end

endmodule

// File: rtl/tp_ctrl_net.sv
module tp_ctrl_net
  import tpn_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              cp_wr,
  input  logic [ADDR_W-1:0] pi,
  input  logic              tp_en,
  input  logic              tp_val,
  input  logic              obs_sel,
  output logic [ADDR_W-1:0] po
);

  localparam int NUM_CP = 1 << ADDR_W;

  cp_cfg_t [NUM_CP-1:0] cfg_q;
  logic    [NUM_CP-1:0] raw_lines;
  logic    [NUM_CP-1:0] ctl_lines;
  logic    [ADDR_W-1:0] func_y;
  logic    [ADDR_W-1:0] obs_y;
  logic    [ADDR_W-1:0] po_d;

  tpn_cfg_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .wr        (cp_wr),
    .addr      (pi),
    .en_in     (tp_en),
    .val_in    (tp_val),
    .cfg_q     (cfg_q)
  );

  tpn_cut_front #(.ADDR_W(ADDR_W)) u_front (
    .x     (pi),
    .lines (raw_lines)
  );

  for (genvar i = 0; i < NUM_CP; i++) begin : g_cp
    tpn_ctrl_point #(.KIND(kind_of(i))) u_cp (
      .line_in   (raw_lines[i]),
      .test_mode (test_mode),
      .cfg       (cfg_q[i]),
      .line_out  (ctl_lines[i])
    );
  end

  tpn_cut_back #(.ADDR_W(ADDR_W)) u_back (
    .lines (ctl_lines),
    .y     (func_y)
  );

  // Observation taps: the first ADDR_W controlled lines
  assign obs_y = ctl_lines[ADDR_W-1:0];
  assign po_d  = (test_mode & obs_sel) ? obs_y : func_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) po <= '0;
    else        po <= po_d;
  end

endmodule

// File: rtl/tp_ctrl_net_chk.sv
module tp_ctrl_net_chk
  import tpn_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int NUM_CP = 1 << ADDR_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 test_mode,
  input logic                 cp_wr,
  input logic [ADDR_W-1:0]    pi,
  input logic                 tp_en,
  input logic [ADDR_W-1:0]    po,
  input cp_cfg_t [NUM_CP-1:0] cfg_q
);

  logic [NUM_CP-1:0] en_vec;
  logic [NUM_CP-1:0] chg;
  cp_cfg_t [NUM_CP-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cfg_q;
  end

  always_comb begin
    for (int i = 0; i < NUM_CP; i++) begin
      en_vec[i] = cfg_q[i].en;
      chg[i]    = (cfg_q[i] != prev_q[i]);
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (po == '0 && en_vec == '0));

  // R3
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_mode && cp_wr) |=> $stable(cfg_q));

  // R3
  single_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && cp_wr) |=> (en_vec[$past(pi)] == $past(tp_en)));

  // R2
  transparent_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !test_mode && $past(!test_mode) && $stable(pi)) |=> $stable(po));

endmodule

bind tp_ctrl_net tp_ctrl_net_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_mode (test_mode),
  .cp_wr     (cp_wr),
  .pi        (pi),
  .tp_en     (tp_en),
  .po        (po),
  .cfg_q     (cfg_q)
);

// File: tb/tp_ctrl_net_tb_top.sv
module tp_ctrl_net_tb_top;

  localparam int AW = 2;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          test_mode = 1'b0;
  logic          cp_wr = 1'b0;
  logic [AW-1:0] pi = '0;
  logic          tp_en = 1'b0;
  logic          tp_val = 1'b0;
  logic          obs_sel = 1'b0;
  logic [AW-1:0] po;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  logic m_en  [N];
  logic m_val [N];

  always #5 clk = ~clk;

  tp_ctrl_net #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .cp_wr(cp_wr),
    .pi(pi), .tp_en(tp_en), .tp_val(tp_val), .obs_sel(obs_sel), .po(po)
  );

  // Reference model built from the requirements
  function automatic logic [AW-1:0] ref_po(logic [AW-1:0] x, logic tm, logic sel);
    logic [N-1:0] b;
    logic [AW-1:0] y;
    for (int i = 0; i < N; i++) begin
      logic a, act;
      a   = (x == AW'(i));
      act = tm & m_en[i];
      case (i % 3)
        0:       b[i] = a & ~act;
        1:       b[i] = a | act;
        default: b[i] = act ? m_val[i] : a;
      endcase
    end
    if (tm && sel) return b[AW-1:0];
    y = '0;
    for (int k = 0; k < N; k++) y[k % AW] = y[k % AW] ^ b[k];
    return y;
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: po actual %b expected %b", req, act, expv);
    end
  endtask

  task automatic do_write(logic tm, logic wr, int addr, logic en, logic val);
    @(negedge clk);
    test_mode = tm; cp_wr = wr; pi = AW'(addr); tp_en = en; tp_val = val; obs_sel = 1'b0;
    if (tm && wr) begin
      m_en[addr]  = en;
      m_val[addr] = val;
    end
  endtask

  task automatic apply(int x, logic tm, logic sel, string req);
    @(negedge clk);
    test_mode = tm; cp_wr = 1'b0; pi = AW'(x); obs_sel = sel;
    tp_en = 1'b1; tp_val = 1'b1;
    exp_q.push_back(ref_po(AW'(x), tm, sel));
    tag_q.push_back(req);
  endtask

  // Monitor: compares one registered result per queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [AW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, po, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_en[i] = 1'b0; m_val[i] = 1'b0; end
    pi = 2'd1;
    repeat (3) @(negedge clk);
    check("R1 reset", po, '0);
    rst_n = 1'b1;

    // R2: transparency, obs_sel ignored
    for (int x = 0; x < N; x++) begin
      apply(x, 1'b0, 1'b0, "R2 functional");
      apply(x, 1'b0, 1'b1, "R2 obs_sel ignored");
    end
    // R1: cleared points leave test mode functional
    for (int x = 0; x < N; x++) apply(x, 1'b1, 1'b0, "R1 cleared points");

    // R4 R5 R6 R7: each point alone
    for (int i = 0; i < N; i++) begin
      string tg;
      tg = (i % 3 == 0) ? "R4 pull-low" : (i % 3 == 1) ? "R5 pull-high" : "R6 replace";
      do_write(1'b1, 1'b1, i, 1'b1, 1'b1);
      for (int x = 0; x < N; x++) begin
        apply(x, 1'b1, 1'b0, tg);
        apply(x, 1'b1, 1'b1, "R7 observe");
      end
      do_write(1'b1, 1'b1, i, 1'b0, 1'b0);
    end

    // R6: replace point with stored 0
    do_write(1'b1, 1'b1, 2, 1'b1, 1'b0);
    for (int x = 0; x < N; x++) begin
      apply(x, 1'b1, 1'b0, "R6 replace value 0");
      apply(x, 1'b1, 1'b1, "R6 observe value 0");
    end
    do_write(1'b1, 1'b1, 2, 1'b0, 1'b0);

    // R3: write ignored outside test mode
    do_write(1'b0, 1'b1, 1, 1'b1, 1'b1);
    for (int x = 0; x < N; x++) apply(x, 1'b1, 1'b1, "R3 write without test mode");
    // R3: no strobe, no write
    do_write(1'b1, 1'b0, 0, 1'b1, 1'b0);
    for (int x = 0; x < N; x++) apply(x, 1'b1, 1'b0, "R3 write without strobe");

    // R2: all points enabled yet test mode off
    for (int i = 0; i < N; i++) do_write(1'b1, 1'b1, i, 1'b1, 1'b1);
    for (int x = 0; x < N; x++) begin
      apply(x, 1'b0, 1'b1, "R2 settings ignored");
      apply(x, 1'b1, 1'b0, "R3 all points active");
    end

    @(negedge clk);
    cp_wr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule